// File: doc/BRIEF.md
# Mode-Selectable Burst Address Counter

This block produces the low two address bits for a four-beat burst. A load pulse captures a 2-bit starting offset and opens a new burst; each later advance moves to the next beat; with neither, the current offset holds and the burst is suspended. The upper address bits are kept elsewhere and are not touched here.

A static mode input picks the beat order. With the mode input low, the order is interleaved: the offset on beat k is the starting offset XOR k. With the mode input high, the order is a linear wrap: the offset on beat k is the starting offset plus k, modulo 4. Internally the block stores only the starting offset and a beat index, and forms the offset from the two. A flag marks the fourth beat of the burst.

Top module: `burst_ofs_ctr`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), `ofs` reads 00 and `last_beat` reads 0.
- R2: A clock edge with `load` high makes `ofs` equal to the `start_ofs` value sampled at that edge, with `last_beat` at 0, in either mode.
- R3: With `linear_mode` at 0 (interleaved), after a load of S and n advances (n = 0..3), `ofs` equals S XOR n; starting at 01 the order is 01, 00, 11, 10.
- R4: With `linear_mode` at 1 (linear), after a load of S and n advances (n = 0..3), `ofs` equals (S + n) mod 4; starting at 10 the order is 10, 11, 00, 01.
- R5: An edge with both `load` and `adv` low leaves `ofs` and `last_beat` unchanged (burst suspended).
- R6: When `load` and `adv` are both high at one edge, the load wins: `ofs` becomes the new `start_ofs` and `last_beat` is 0.
- R7: `last_beat` is 1 exactly when three advances have occurred since the last load (the fourth beat), and 0 otherwise.
- R8: An advance taken on the fourth beat wraps: `ofs` returns to the starting offset and `last_beat` falls to 0.
- R9: A load in the middle of a burst restarts it: the beat count restarts from the new starting offset, whatever the old burst position was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| linear_mode | input | 1 | Beat order: 0 interleaved, 1 linear wrap; held static |
| load | input | 1 | Start a new burst from `start_ofs` |
| start_ofs | input | 2 | Starting offset captured on load |
| adv | input | 1 | Advance to the next beat |
| ofs | output | 2 | Current burst offset (low address bits) |
| last_beat | output | 1 | High on the fourth beat of the burst |

## Verification
The bound checker watches every cycle for the local step rules: a load lands the sampled start value with the flag clear, an idle edge changes nothing, a linear advance adds one, an interleaved advance always flips the lowest bit, and an advance off the last beat clears the flag. Those rules cannot show that a full interleaved sequence visits the right values in the right order from each start, nor that the wrap lands back on the start; the bench's table of all eight start and mode pairs, its suspended-burst holds and its mid-burst reloads cover that.

// File: rtl/burst_ofs_ctr.sv
module burst_ofs_ctr #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             linear_mode,
  input  logic             load,
  input  logic [OFS_W-1:0] start_ofs,
  input  logic             adv,
  output logic [OFS_W-1:0] ofs,
  output logic             last_beat
);
  localparam logic [OFS_W-1:0] BEAT_LAST = {OFS_W{1'b1}};

  logic [OFS_W-1:0] base_q;
  logic [OFS_W-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= start_ofs;
      beat_q <= '0;
    end else if (adv) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign ofs       = linear_mode ? base_q + beat_q : base_q ^ beat_q;
  assign last_beat = (beat_q == BEAT_LAST);
endmodule

module burst_ofs_ctr_chk #(
  parameter int OFS_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             linear_mode,
  input logic             load,
  input logic [OFS_W-1:0] start_ofs,
  input logic             adv,
  input logic [OFS_W-1:0] ofs,
  input logic             last_beat
);
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (ofs == $past(start_ofs)) && !last_beat);

  p_load_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (load && adv) |=> !last_beat);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(ofs) && $stable(last_beat));

  p_lin_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && adv && linear_mode) |=> ofs == OFS_W'($past(ofs) + 1'b1));

  p_ilv_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && adv && !linear_mode) |=> ofs[0] != $past(ofs[0]));

  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && adv && last_beat) |=> !last_beat);
endmodule

bind burst_ofs_ctr burst_ofs_ctr_chk #(.OFS_W(OFS_W)) u_chk (.*);

// File: tb/burst_ofs_ctr_tb.sv
module burst_ofs_ctr_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       linear_mode = 1'b0;
  logic       load = 1'b0;
  logic [1:0] start_ofs = 2'd0;
  logic       adv = 1'b0;
  logic [1:0] ofs;
  logic       last_beat;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_ofs_ctr u_dut (.*);

  // {mode, start, beat0, beat1, beat2, beat3, wrap}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0},
    {1'b0, 2'd1, 2'd1, 2'd0, 2'd3, 2'd2, 2'd1},
    {1'b0, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2},
    {1'b0, 2'd3, 2'd3, 2'd2, 2'd1, 2'd0, 2'd3},
    {1'b1, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0},
    {1'b1, 2'd1, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1},
    {1'b1, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2},
    {1'b1, 2'd3, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3}
  };

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick(input logic ld, input logic [1:0] s, input logic a);
    load = ld; start_ofs = s; adv = a;
    @(negedge clk);
    load = 1'b0; adv = 1'b0;
  endtask

  task automatic do_reset(input logic m);
    rst = 1'b1; linear_mode = m;
    tick(1'b0, 2'd0, 1'b0);
    tick(1'b0, 2'd0, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset(1'b0);
    check("R1 ofs after reset", ofs, 0);
    check("R1 last_beat after reset", last_beat, 0);

    for (int i = 0; i < 8; i++) begin
      logic m;
      logic [1:0] s;
      string rq;
      m  = VEC[i][12];
      s  = VEC[i][11:10];
      rq = m ? "R4" : "R3";
      do_reset(m);
      tick(1'b1, s, 1'b0);
      check("R2 load ofs", ofs, int'(VEC[i][9:8]));
      check("R2 load last_beat", last_beat, 0);
      for (int b = 1; b <= 4; b++) begin
        tick(1'b0, 2'd0, 1'b1);
        check({rq, " beat ofs"}, ofs, int'(VEC[i][9-2*b -: 2]));
        check("R7 last_beat", last_beat, (b == 3) ? 1 : 0);
        if (b == 2) begin
          tick(1'b0, 2'd0, 1'b0);
          check("R5 suspended ofs", ofs, int'(VEC[i][9-2*b -: 2]));
        end
      end
      check("R8 wrap to start", ofs, int'(s));
    end

    do_reset(1'b1);
    tick(1'b1, 2'd1, 1'b0);
    tick(1'b0, 2'd0, 1'b1);
    tick(1'b0, 2'd0, 1'b1);
    tick(1'b0, 2'd0, 1'b1);
    check("R7 last beat reached", last_beat, 1);
    for (int h = 0; h < 3; h++) begin
      tick(1'b0, 2'd0, 1'b0);
      check("R5 hold ofs on last beat", ofs, 0);
      check("R5 hold last_beat", last_beat, 1);
    end
    tick(1'b1, 2'd2, 1'b1);
    check("R6 load beats adv ofs", ofs, 2);
    check("R6 load beats adv last_beat", last_beat, 0);
    tick(1'b0, 2'd0, 1'b1);
    check("R4 after priority load", ofs, 3);

    do_reset(1'b0);
    tick(1'b1, 2'd3, 1'b0);
    tick(1'b0, 2'd0, 1'b1);
    tick(1'b0, 2'd0, 1'b1);
    check("R3 mid burst", ofs, 1);
    tick(1'b1, 2'd1, 1'b0);
    check("R9 reload ofs", ofs, 1);
    tick(1'b0, 2'd0, 1'b1);
    check("R9 reload beat1", ofs, 0);
    tick(1'b0, 2'd0, 1'b1);
    tick(1'b0, 2'd0, 1'b1);
    check("R9 reload beat3", ofs, 2);
    check("R9 reload last_beat", last_beat, 1);

    tick(1'b0, 2'd0, 1'b1);
    rst = 1'b1;
    tick(1'b0, 2'd0, 1'b1);
    rst = 1'b0;
    check("R1 reset mid burst ofs", ofs, 0);
    check("R1 reset mid burst last_beat", last_beat, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule